// File: doc/BRIEF.md
# Ethernet Channel Event and Interrupt Mask Unit

This block gathers event pulses from an Ethernet channel controller into a 16-bit sticky event register and combines them with a 16-bit enable register to drive one interrupt request. Six event sources are recorded: graceful-stop completion, transmit error, receive frame, busy, transmit buffer and receive buffer. Software reads either register over a simple register bus. It writes the enable register directly and clears event bits by writing ones to them.

The block also decides when a graceful stop has completed. A stop command that arrives while no frame is being sent completes at once. A stop command that arrives during a frame completes only when that frame ends. The interrupt output is registered and stays high as long as any enabled event remains pending.

Top module: `eth_event_ctrl`

## Requirements
- R1: After reset, the event register, the enable register, `bus_rdata` and `irq` are all zero.
- R2: A write with `bus_sel`=0 clears every event bit whose data bit is 1. Event bits whose data bit is 0 keep their value.
- R3: A write with `bus_sel`=1 loads the enable register from the implemented bits of `bus_wdata`.
- R4: `irq` is registered. One cycle after the registers change, it equals the OR over all bits of (event AND enable). It stays high until every enabled pending bit has been cleared, and masked pending bits do not drive it.
- R5: A `stop_cmd` pulse while `frame_active` is 0 sets event bit 8 at the next clock edge.
- R6: A `stop_cmd` pulse while `frame_active` is 1 leaves bit 8 clear until `frame_active` falls. The bit is set at the first edge where `frame_active` is 0.
- R7: The pulse inputs set these event bits at the next edge: `tx_err_pulse` sets bit 11, `rx_frame_pulse` sets bit 12, `busy_pulse` sets bit 13, `txbuf_pulse` sets bit 14 and `rxbuf_pulse` sets bit 15.
- R8: Bits 0–7, 9 and 10 of both registers always read as zero, and writes to them are ignored (implemented mask 0xF900).
- R9: If a hardware set and a software clear hit the same event bit in the same cycle, the bit ends up set.
- R10: `bus_rdata` is registered. One cycle after a clock edge, it shows the register that `bus_sel` selected at that edge: 0 selects the event register and 1 selects the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_sel | input | 1 | Register select: 0 = event, 1 = enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| stop_cmd | input | 1 | Graceful-stop command pulse |
| frame_active | input | 1 | High while a frame is being transmitted |
| tx_err_pulse | input | 1 | Transmit error event pulse |
| rx_frame_pulse | input | 1 | Complete frame received pulse |
| busy_pulse | input | 1 | Busy event pulse |
| txbuf_pulse | input | 1 | Transmit buffer event pulse |
| rxbuf_pulse | input | 1 | Receive buffer event pulse |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that `frame_active` changes only at clock edges and is a steady level, not a pulse. They also assume that each event input is a one-cycle pulse, so that a bit set at one edge can only be observed at the next. The stimulus drives every input on the falling edge and holds `frame_active` low during the source sweep. It raises `frame_active` only in the graceful-stop sequence, where it stays high for several cycles before it drops.

// File: rtl/eth_evt_pkg.sv
package eth_evt_pkg;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned NUM_SRC = 6;

  typedef logic [REG_W-1:0] reg_t;

  // source index -> event bit position
  function automatic int unsigned src_pos(input int unsigned idx);
    case (idx)
      0:       return 8;   // graceful stop complete
      1:       return 11;  // transmit error
      2:       return 12;  // receive frame
      3:       return 13;  // busy
      4:       return 14;  // transmit buffer
      default: return 15;  // receive buffer
    endcase
  endfunction

  // sources that feed a given bit position
  function automatic logic [NUM_SRC-1:0] srcs_at(input int unsigned pos);
    logic [NUM_SRC-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < NUM_SRC; i++)
      if (src_pos(i) == pos) m[i] = 1'b1;
    return m;
  endfunction

  function automatic reg_t impl_bits();
    reg_t m;
    m = '0;
    for (int unsigned i = 0; i < NUM_SRC; i++) m[src_pos(i)] = 1'b1;
    return m;
  endfunction

  localparam reg_t IMPL_MASK = impl_bits();
endpackage

// File: rtl/evt_gstop_track.sv
module evt_gstop_track (
  input  logic clk,
  input  logic rst,
  input  logic stop_cmd,
  input  logic frame_active,
  output logic done
);
  logic waiting_q;

  always_ff @(posedge clk) begin
    if (rst)
      waiting_q <= 1'b0;
    else if (!frame_active)
      waiting_q <= 1'b0;
    else if (stop_cmd)
      waiting_q <= 1'b1;
  end

  assign done = (stop_cmd | waiting_q) & ~frame_active;

  // R5: idle transmitter completes the stop at once
  assert_stop_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (stop_cmd && !frame_active) |-> done)
    else $error("graceful stop not immediate while idle");

  // R6: no completion while a frame is still on the wire
  assert_stop_wait_R6: assert property (@(posedge clk) disable iff (rst)
    frame_active |-> !done)
    else $error("graceful stop completed during a frame");

  // R6: a pending stop completes on the edge where the frame has ended
  assert_stop_pending_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(frame_active) && $past(stop_cmd) && !frame_active) |-> done)
    else $error("pending graceful stop lost");
endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg
  import eth_evt_pkg::*;
#(
  parameter int unsigned W     = REG_W,
  parameter int unsigned N_SRC = NUM_SRC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_pulse,
  input  logic             clr_en,
  input  logic [W-1:0]     clr_data,
  output logic [W-1:0]     evt_q
);
  localparam logic [W-1:0] IMPL = W'(IMPL_MASK);

  logic [W-1:0] set_vec;
  logic [W-1:0] clr_vec;

  for (genvar g = 0; g < W; g++) begin : g_set
    localparam logic [N_SRC-1:0] SEL = N_SRC'(srcs_at(g));
    assign set_vec[g] = |(src_pulse & SEL);
  end

  assign clr_vec = clr_en ? clr_data : '0;

  always_ff @(posedge clk) begin
    if (rst) evt_q <= '0;
    else     evt_q <= ((evt_q & ~clr_vec) | set_vec) & IMPL;
  end

  // R2: bits written with one (and not set at the same time) are cleared
  assert_w1c_R2: assert property (@(posedge clk) disable iff (rst)
    (clr_en && |(clr_data & IMPL & ~set_vec))
      |=> ((evt_q & $past(clr_data & IMPL & ~set_vec)) == '0))
    else $error("write-one-to-clear failed");

  // R9: hardware set always lands, even against a clear
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((evt_q & $past(set_vec)) == $past(set_vec)))
    else $error("event set lost");
endmodule

// File: rtl/evt_mask_irq.sv
module evt_mask_irq
  import eth_evt_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mask_wr,
  input  logic [W-1:0] mask_wdata,
  input  logic [W-1:0] evt,
  output logic [W-1:0] mask_q,
  output logic         irq
);
  localparam logic [W-1:0] IMPL = W'(IMPL_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= mask_wdata & IMPL;
      irq <= |(evt & mask_q);
    end
  end

  // R4: request follows enabled pending events one cycle later
  assert_irq_follow_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(evt & mask_q))))
    else $error("interrupt does not track enabled events");

  // R4: request held while any enabled event is still pending
  assert_irq_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (irq && |(evt & mask_q)) |=> irq)
    else $error("interrupt dropped with enabled event pending");
endmodule

// File: rtl/eth_event_ctrl.sv
module eth_event_ctrl
  import eth_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_sel,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             stop_cmd,
  input  logic             frame_active,
  input  logic             tx_err_pulse,
  input  logic             rx_frame_pulse,
  input  logic             busy_pulse,
  input  logic             txbuf_pulse,
  input  logic             rxbuf_pulse,
  output logic             irq
);
  logic               gstop_done;
  logic [NUM_SRC-1:0] src_pulse;
  reg_t               evt_q;
  reg_t               mask_q;

  evt_gstop_track u_gstop (
    .clk          (clk),
    .rst          (rst),
    .stop_cmd     (stop_cmd),
    .frame_active (frame_active),
    .done         (gstop_done)
  );

  // index order matches eth_evt_pkg::src_pos
  assign src_pulse = {rxbuf_pulse, txbuf_pulse, busy_pulse,
                      rx_frame_pulse, tx_err_pulse, gstop_done};

  evt_status_reg #(.W(REG_W), .N_SRC(NUM_SRC)) u_evt (
    .clk       (clk),
    .rst       (rst),
    .src_pulse (src_pulse),
    .clr_en    (bus_wr & ~bus_sel),
    .clr_data  (bus_wdata),
    .evt_q     (evt_q)
  );

  evt_mask_irq #(.W(REG_W)) u_mask (
    .clk        (clk),
    .rst        (rst),
    .mask_wr    (bus_wr & bus_sel),
    .mask_wdata (bus_wdata),
    .evt        (evt_q),
    .mask_q     (mask_q),
    .irq        (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_sel ? mask_q : evt_q;
  end

  // R8: reserved positions never appear on the read port
  assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata & ~IMPL_MASK) == '0)
    else $error("reserved bit read as one");
endmodule

// File: tb/eth_event_ctrl_test.sv
`timescale 1ns/1ps
module eth_event_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_sel = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        stop_cmd = 0, frame_active = 0;
  logic        tx_err_pulse = 0, rx_frame_pulse = 0, busy_pulse = 0;
  logic        txbuf_pulse = 0, rxbuf_pulse = 0;
  logic        irq;

  int total = 0, fails = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  eth_event_ctrl uut (.*);

  function automatic logic [15:0] expand(input logic [5:0] s);
    logic [15:0] v;
    v = '0;
    v[8] = s[0]; v[11] = s[1]; v[12] = s[2];
    v[13] = s[3]; v[14] = s[4]; v[15] = s[5];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic sel, output logic [15:0] d);
    @(negedge clk);
    bus_sel = sel;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [5:0] s);
    @(negedge clk);
    stop_cmd = s[0]; tx_err_pulse = s[1]; rx_frame_pulse = s[2];
    busy_pulse = s[3]; txbuf_pulse = s[4]; rxbuf_pulse = s[5];
    @(negedge clk);
    {stop_cmd, tx_err_pulse, rx_frame_pulse, busy_pulse, txbuf_pulse, rxbuf_pulse} = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 irq", {15'd0, irq}, 16'h0);
    chk("R1 rdata", bus_rdata, 16'h0);
    rd(0, r); chk("R1 event", r, 16'h0);
    rd(1, r); chk("R1 mask", r, 16'h0);

    // R8 reserved bits in mask
    wr(1, 16'hFFFF); rd(1, r); chk("R8 mask all ones", r, 16'hF900);
    wr(1, 16'h06FF); rd(1, r); chk("R8 mask reserved only", r, 16'h0000);
    // R10 read select
    wr(1, 16'hA800); rd(1, r); chk("R10 select enable", r, 16'hA800);
    rd(0, r); chk("R10 select event", r, 16'h0000);

    // R2 write-one-to-clear
    pulse(6'h3F); rd(0, r); chk("R7 all sources", r, 16'hF900);
    wr(0, 16'h0000); rd(0, r); chk("R2 zero write", r, 16'hF900);
    wr(0, 16'h06FF); rd(0, r); chk("R8 event reserved write", r, 16'hF900);
    wr(0, 16'h2000); rd(0, r); chk("R2 single clear", r, 16'hD900);
    wr(0, 16'hFFFF); rd(0, r); chk("R2 full clear", r, 16'h0000);

    // R9 set beats clear
    @(negedge clk);
    bus_wr = 1; bus_sel = 0; bus_wdata = 16'h1800; rx_frame_pulse = 1;
    @(negedge clk);
    bus_wr = 0; bus_wdata = '0; rx_frame_pulse = 0;
    rd(0, r); chk("R9 set wins", r, 16'h1000);
    wr(0, 16'hFFFF);

    // R4 hold until every enabled bit cleared
    wr(1, 16'h1800);
    pulse(6'b001110);  // bits 11,12,13
    @(negedge clk);
    chk("R4 irq set", {15'd0, irq}, 16'h1);
    wr(0, 16'h0800); @(negedge clk);
    chk("R4 irq held", {15'd0, irq}, 16'h1);
    wr(0, 16'h1000); @(negedge clk);
    chk("R4 masked pending ignored", {15'd0, irq}, 16'h0);
    wr(0, 16'hFFFF); wr(1, 16'h0000);

    // R5 idle stop
    pulse(6'h01); rd(0, r); chk("R5 idle stop", r, 16'h0100);
    wr(0, 16'hFFFF);
    // R6 stop during frame
    @(negedge clk); frame_active = 1;
    pulse(6'h01);
    repeat (4) @(negedge clk);
    rd(0, r); chk("R6 still waiting", r, 16'h0000);
    frame_active = 0;
    @(negedge clk);
    chk("R6 done when frame ends", bus_rdata, 16'h0000);
    rd(0, r); chk("R6 done bit", r, 16'h0100);
    wr(0, 16'hFFFF);

    // R3/R4/R7 sweep of every enable x event combination
    for (int m = 0; m < 64; m++) begin
      wr(1, expand(6'(m)) | 16'h06FF);
      rd(1, r); chk("R3 enable load", r, expand(6'(m)));
      for (int e = 0; e < 64; e++) begin
        wr(0, 16'hFFFF);
        pulse(6'(e));
        @(negedge clk);
        chk("R4 irq sweep", {15'd0, irq}, {15'd0, |(6'(e) & 6'(m))});
        rd(0, r); chk("R7 event sweep", r, expand(6'(e)));
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule